// File: doc/BRIEF.md
# BCD Nine's Complementer with Code Validation

This unit takes one binary-coded decimal digit and two controls: a zero-force input and a complement-select input. It drives a result digit and an error flag. If the input is a valid decimal digit, the result is one of three things. It is the digit itself, or its nine's complement, or zero when zero-force is set. The six four-bit codes above nine are not decimal digits. For any of those codes the unit blanks the result to zero and raises the error flag.

The unit sits beside a BCD adder. Subtraction is then done as complement-then-add, one digit slice per decade. A parameter chooses between two variants. One is purely combinational. The other puts a register stage on the result and the flag, so that a timing path can be measured from clock to clock.

Top module: `bcd_ninecomp_unit`

## Requirements
- R1: With REG_OUT = 1, while rst_n is low, digit_out is 0000 and err_out is 0, whatever the inputs are.
- R2: When zero_force is 1 and digit_in is a legal digit (0000 to 1001), digit_out is 0000.
- R3: For digit_in codes 1010 to 1111, err_out is 1 and digit_out is 0000. This holds for any value of zero_force and comp_sel.
- R4: For legal digit_in codes (0000 to 1001), err_out is 0 for any value of zero_force and comp_sel.
- R5: When comp_sel is 1, zero_force is 0 and digit_in is legal, digit_out equals 9 minus digit_in. For example, 0 gives 9, 3 gives 6 and 9 gives 0.
- R6: When comp_sel is 0, zero_force is 0 and digit_in is legal, digit_out equals digit_in.
- R7: digit_out is always a legal BCD code, that is, 1001 or below.
- R8: With REG_OUT = 1, the outputs take the value computed from the inputs that were present at the previous rising clk edge. Between edges they hold steady. With REG_OUT = 0, the outputs follow the inputs with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant; unused when REG_OUT = 0 |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| digit_in | input | 4 | BCD digit operand |
| zero_force | input | 1 | 1 forces the result digit to zero |
| comp_sel | input | 1 | 1 selects the nine's complement, 0 selects pass-through |
| digit_out | output | 4 | Result digit |
| err_out | output | 1 | 1 when digit_in is not a legal BCD code |

## Verification
The bench builds two instances side by side on the same inputs. One uses REG_OUT = 1 and the other uses REG_OUT = 0. This puts the combinational decode and the register stage under one stimulus. The registered instance shows the reset clearing and the one-cycle delay, while the combinational instance shows the same-cycle results. The exhaustive sweep covers every pairing of code, zero-force and complement-select on both variants. It therefore reaches the priority corner where an illegal code meets zero-force or complement-select.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;
   localparam int BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_t;
   localparam bcd_t BCD_TOP  = 4'd9;
   localparam bcd_t BCD_ZERO = 4'd0;

   typedef enum logic [1:0] {
      PATH_PASS  = 2'd0,
      PATH_NINES = 2'd1,
      PATH_BLANK = 2'd2
   } path_e;
endpackage

// File: rtl/bcdc_code_check.sv
module bcdc_code_check (
   input  logic [3:1] hi_bits,
   output logic       legal
);
   // A code is above nine exactly when bit 3 is set together with bit 2 or bit 1.
   always_comb begin
      legal = ~(hi_bits[3] & (hi_bits[2] | hi_bits[1]));
   end
endmodule

// File: rtl/bcdc_nines.sv
module bcdc_nines
   import bcdc_pkg::*;
(
   input  bcd_t d,
   output bcd_t q
);
   // Gate form of 9 - d; the result is meaningful only for legal digits.
   always_comb begin
      q[3] = ~d[3] & ~d[2] & ~d[1];
      q[2] = d[2] ^ d[1];
      q[1] = d[1];
      q[0] = ~d[0];
   end
endmodule

// File: rtl/bcdc_path_sel.sv
module bcdc_path_sel
   import bcdc_pkg::*;
(
   input  logic legal,
   input  logic zero_force,
   input  logic comp_sel,
   input  bcd_t direct,
   input  bcd_t nines,
   output bcd_t result,
   output logic flag
);
   path_e path;

   // Priority: illegal code and zero-force blank; comp_sel decides only afterwards.
   always_comb begin
      if (!legal || zero_force) begin
         path = PATH_BLANK;
      end else if (comp_sel) begin
         path = PATH_NINES;
      end else begin
         path = PATH_PASS;
      end
   end

   always_comb begin
      unique case (path)
         PATH_PASS:  result = direct;
         PATH_NINES: result = nines;
         default:    result = BCD_ZERO;
      endcase
      flag = ~legal;
   end
endmodule

// File: rtl/bcd_ninecomp_unit.sv
module bcd_ninecomp_unit
   import bcdc_pkg::*;
#(
   parameter int REG_OUT = 1,
   parameter int DIGIT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIGIT_W-1:0] digit_in,
   input  logic               zero_force,
   input  logic               comp_sel,
   output logic [DIGIT_W-1:0] digit_out,
   output logic               err_out
);
   localparam bit USE_REG = (REG_OUT != 0);

   if (DIGIT_W != BCD_W) begin : g_bad_width
      $error("bcd_ninecomp_unit: DIGIT_W must equal %0d", BCD_W);
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("bcd_ninecomp_unit: REG_OUT must be 0 or 1");
   end

   logic is_legal;
   bcd_t nines_val;
   bcd_t sel_val;
   logic sel_err;

   bcdc_code_check u_check (
      .hi_bits (digit_in[3:1]),
      .legal   (is_legal)
   );

   bcdc_nines u_nines (
      .d (digit_in),
      .q (nines_val)
   );

   bcdc_path_sel u_sel (
      .legal      (is_legal),
      .zero_force (zero_force),
      .comp_sel   (comp_sel),
      .direct     (digit_in),
      .nines      (nines_val),
      .result     (sel_val),
      .flag       (sel_err)
   );

   if (USE_REG) begin : g_reg
      bcd_t digit_q;
      logic err_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            digit_q <= BCD_ZERO;
            err_q   <= 1'b0;
         end else begin
            digit_q <= sel_val;
            err_q   <= sel_err;
         end
      end
      assign digit_out = digit_q;
      assign err_out   = err_q;
   end else begin : g_comb
      assign digit_out = sel_val;
      assign err_out   = sel_err;
   end
endmodule

// File: rtl/bcdc_checker.sv
module bcdc_checker #(
   parameter int REG_OUT = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] digit_in,
   input logic       zero_force,
   input logic       comp_sel,
   input logic [3:0] digit_out,
   input logic       err_out
);
   if (REG_OUT != 0) begin : g_seq
      // R2
      a_r2_zero_blank: assert property (@(posedge clk) disable iff (!rst_n)
         zero_force |=> digit_out == 4'd0);
      // R3
      a_r3_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (digit_in > 4'd9) |=> (err_out && digit_out == 4'd0));
      // R4
      a_r4_legal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (digit_in <= 4'd9) |=> !err_out);
      // R5
      a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
         (digit_in <= 4'd9 && !zero_force && comp_sel) |=>
            digit_out == 4'(4'd9 - $past(digit_in)));
      // R6
      a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (digit_in <= 4'd9 && !zero_force && !comp_sel) |=>
            digit_out == $past(digit_in));
   end else begin : g_comb
      // R2
      a_r2_zero_blank: assert property (@(posedge clk) disable iff (!rst_n)
         zero_force |-> digit_out == 4'd0);
      // R3
      a_r3_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (digit_in > 4'd9) |-> (err_out && digit_out == 4'd0));
      // R4
      a_r4_legal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (digit_in <= 4'd9) |-> !err_out);
      // R5
      a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
         (digit_in <= 4'd9 && !zero_force && comp_sel) |->
            digit_out == 4'(4'd9 - digit_in));
      // R6
      a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (digit_in <= 4'd9 && !zero_force && !comp_sel) |->
            digit_out == digit_in);
   end
   // R7
   a_r7_out_range: assert property (@(posedge clk) disable iff (!rst_n)
      digit_out <= 4'd9);
endmodule

bind bcd_ninecomp_unit bcdc_checker #(.REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .digit_in   (digit_in),
   .zero_force (zero_force),
   .comp_sel   (comp_sel),
   .digit_out  (digit_out),
   .err_out    (err_out)
);

// File: tb/sim_bcd_ninecomp_unit.sv
`timescale 1ns/1ps
module sim_bcd_ninecomp_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] a = 4'd0;
   logic       z = 1'b0;
   logic       c = 1'b0;
   logic [3:0] f_reg, f_cmb;
   logic       e_reg, e_cmb;
   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   bcd_ninecomp_unit #(.REG_OUT(1)) u0 (
      .clk(clk), .rst_n(rst_n), .digit_in(a), .zero_force(z), .comp_sel(c),
      .digit_out(f_reg), .err_out(e_reg));

   bcd_ninecomp_unit #(.REG_OUT(0)) u1 (
      .clk(clk), .rst_n(rst_n), .digit_in(a), .zero_force(z), .comp_sel(c),
      .digit_out(f_cmb), .err_out(e_cmb));

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (a=%0d z=%0d c=%0d)",
                  tag, act, exp, a, z, c);
      end
   endtask

   function automatic void ref_model(input logic [3:0] d, input logic zf,
                                     input logic cs, output logic [3:0] f,
                                     output logic e);
      if (d > 4'd9) begin f = 4'd0; e = 1'b1; end
      else if (zf)  begin f = 4'd0; e = 1'b0; end
      else if (cs)  begin f = 4'(4'd9 - d); e = 1'b0; end
      else          begin f = d; e = 1'b0; end
   endfunction

   function automatic string tag_of(input logic [3:0] d, input logic zf,
                                    input logic cs);
      if (d > 4'd9) return "R3";
      if (zf) return "R2";
      if (cs) return "R5";
      return "R6";
   endfunction

   task automatic drive(input logic [3:0] d, input logic zf, input logic cs);
      @(negedge clk);
      a = d; z = zf; c = cs;
   endtask

   // R1: reset state of the registered variant, with an illegal code applied
   task automatic t_reset();
      drive(4'd12, 1'b0, 1'b1);
      @(posedge clk); #1;
      chk("R1 digit_out in reset", f_reg, 0);
      chk("R1 err_out in reset", e_reg, 0);
      chk("R3 comb during reset err", e_cmb, 1);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Exhaustive sweep of all 64 input combinations on both variants
   task automatic t_sweep();
      for (int i = 0; i < 64; i++) begin
         logic [3:0] ef;
         logic ee;
         drive(4'(i >> 2), i[1], i[0]);
         ref_model(a, z, c, ef, ee);
         #1;
         chk({tag_of(a, z, c), " comb F"}, f_cmb, ef);
         chk((a > 4'd9) ? "R3 comb E" : "R4 comb E", e_cmb, ee);
         chk("R7 comb range", (f_cmb <= 4'd9) ? 1 : 0, 1);
         @(posedge clk); #1;
         chk({tag_of(a, z, c), " reg F"}, f_reg, ef);
         chk((a > 4'd9) ? "R3 reg E" : "R4 reg E", e_reg, ee);
         chk("R7 reg range", (f_reg <= 4'd9) ? 1 : 0, 1);
      end
   endtask

   // R5: named complement examples
   task automatic t_examples();
      drive(4'd0, 1'b0, 1'b1); #1; chk("R5 0->9", f_cmb, 9);
      drive(4'd3, 1'b0, 1'b1); #1; chk("R5 3->6", f_cmb, 6);
      drive(4'd9, 1'b0, 1'b1); #1; chk("R5 9->0", f_cmb, 0);
   endtask

   // R3: illegal codes win over zero-force and complement
   task automatic t_illegal_priority();
      drive(4'd15, 1'b1, 1'b1); #1;
      chk("R3 15 z c err", e_cmb, 1);
      chk("R3 15 z c F", f_cmb, 0);
      drive(4'd10, 1'b0, 1'b1); #1;
      chk("R3 10 c F", f_cmb, 0);
   endtask

   // R8: one-cycle latency and hold between edges
   task automatic t_latency();
      drive(4'd3, 1'b0, 1'b1);
      @(posedge clk); #1;
      chk("R8 first value", f_reg, 6);
      drive(4'd5, 1'b0, 1'b0); #1;
      chk("R8 hold before edge", f_reg, 6);
      chk("R8 comb immediate", f_cmb, 5);
      @(posedge clk); #1;
      chk("R8 after edge", f_reg, 5);
      drive(4'd11, 1'b0, 1'b0); #1;
      chk("R8 err hold before edge", e_reg, 0);
      @(posedge clk); #1;
      chk("R8 err after edge", e_reg, 1);
   endtask

   initial begin
      t_reset();
      t_sweep();
      t_examples();
      t_illegal_priority();
      t_latency();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule